// File: doc/BRIEF.md
# Cyclic Sense Wake Controller

This controller runs while the chip sits in one of its two low-power modes (stop or sleep). Driven by a slow-clock tick input, it either raises a wake request after a programmable number of ticks (timer wake), or it periodically switches on a high-side driver to bias external contacts. While that driver is on, it takes one snapshot of the monitor inputs at a programmed tick offset. The snapshot is judged against either the snapshot from the previous period or a fixed target pattern. A positive judgement requests an immediate return to active mode.

Software arms the controller by setting the configuration inputs and then issuing a stop or a sleep command. Arming with a stop command also allows the external sensor supply to be switched together with the high-side driver. The ordinary external wake sources stay live the whole time the controller is armed. Any wake ends the armed session, and the controller returns to idle. Configuration must be held stable while armed.

States: `ST_IDLE` (not armed), `ST_BIAS` (armed, high-side driver on), `ST_REST` (armed, driver off), `ST_WAKE` (one-cycle wake request). Transitions: arm (IDLE to BIAS or REST), bias end (BIAS to REST when the next phase reaches the on-time), period restart (REST to BIAS on phase wrap in sense mode), sense hit, timer expiry and external wake (BIAS/REST to WAKE), and release (WAKE to IDLE).

Top module: `cyc_sense_wake`

## Requirements
- R1: After reset, hs_en, sup_en, sample_stb and wake_req are 0 and wake_src is 0.
- R2: A stop or sleep command (arm_stop / arm_sleep high for one cycle) arms the controller only when cfg_mode is 1 (timer wake) or 2 (sense). Mode codes 0 and 3 mean off: the command is ignored, the driver stays off and no tick produces a wake.
- R3: In timer-wake mode, wake_req rises in the cycle after the cfg_period-th tick counted from arming; a period of 0 acts as 1. wake_src then reads 1 (timer).
- R4: In sense mode, before tick k (k counted from 0 at arming), hs_en equals ((k mod P) < cfg_on_time), where P is cfg_period. An on-time of 0 never drives the switch.
- R5: sample_stb is a one-cycle pulse in the cycle after the tick whose phase equals cfg_win_start, and only when cfg_win_start < cfg_on_time. No pulse is produced otherwise.
- R6: With cfg_cmp_prev = 0, a snapshot equal to cfg_target wakes the controller, and wake_src reads 2 (sense).
- R7: With cfg_cmp_prev = 1, a snapshot that differs from the previous period's snapshot wakes the controller, and wake_src reads 2.
- R8: With cfg_cmp_prev = 1, the first snapshot after arming only loads the history and never wakes.
- R9: sup_en follows hs_en only when the session was armed by a stop command with cfg_sup_en = 1; after a sleep command it stays 0.
- R10: ext_wake high while armed gives wake_req in the next cycle with wake_src = 3 (external). While idle, ext_wake has no effect.
- R11: wake_req is a single-cycle pulse. Afterwards the controller is idle: hs_en is 0 and further ticks give no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle slow-clock tick enable |
| arm_stop | input | 1 | Stop command (arms in stop mode) |
| arm_sleep | input | 1 | Sleep command (arms in sleep mode) |
| ext_wake | input | 1 | Combined normal wake sources |
| cfg_mode | input | 2 | 0/3 off, 1 timer wake, 2 sense |
| cfg_cmp_prev | input | 1 | 1: compare with previous snapshot, 0: compare with target |
| cfg_sup_en | input | 1 | Allow sensor-supply switching in stop mode |
| cfg_period | input | CNT_W | Period in ticks |
| cfg_on_time | input | CNT_W | Driver on-time in ticks |
| cfg_win_start | input | CNT_W | Sample tick offset within the period |
| cfg_target | input | MON_W | Target pattern |
| mon_in | input | MON_W | Monitor input levels |
| hs_en | output | 1 | High-side switch enable |
| sup_en | output | 1 | External sensor supply enable |
| sample_stb | output | 1 | Snapshot taken |
| wake_req | output | 1 | Request entry to active mode |
| wake_src | output | 2 | Last wake cause: 1 timer, 2 sense, 3 external |

## Verification
A wrong phase count shows on hs_en within one period, as an on-window of the wrong length or position. It shows on sample_stb within the same period. A stuck or wrongly loaded history register hides itself until the second window after arming, so the compare-to-previous case is driven for several periods, with a change placed just before a known window. A lost return to idle shows as hs_en staying high, or as a second wake_req, on the next tick after a wake.

// File: rtl/csw_pkg.sv
package csw_pkg;
    localparam logic [1:0] CM_OFF   = 2'd0;
    localparam logic [1:0] CM_TIMER = 2'd1;
    localparam logic [1:0] CM_SENSE = 2'd2;

    localparam logic [1:0] SRC_NONE  = 2'd0;
    localparam logic [1:0] SRC_TIMER = 2'd1;
    localparam logic [1:0] SRC_SENSE = 2'd2;
    localparam logic [1:0] SRC_EXT   = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BIAS = 2'd1,
        ST_REST = 2'd2,
        ST_WAKE = 2'd3
    } csw_state_e;
endpackage

// File: rtl/csw_phase_timer.sv
module csw_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] phase,
    output logic [CNT_W-1:0] phase_nxt,
    output logic             wrap
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] phase_q;
    logic [EXT_W-1:0] inc;

    always_comb begin
        inc       = {1'b0, phase_q} + {{CNT_W{1'b0}}, 1'b1};
        wrap      = (inc >= {1'b0, period});
        phase_nxt = wrap ? '0 : inc[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phase_q <= '0;
        else if (clr) phase_q <= '0;
        else if (adv) phase_q <= phase_nxt;
    end

    assign phase = phase_q;

    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && wrap) |=> (phase == '0)); // R4
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase == '0)); // R4
endmodule

// File: rtl/csw_pattern_eval.sv
module csw_pattern_eval #(
    parameter int MON_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp,
    input  logic             cmp_prev,
    input  logic [MON_W-1:0] target,
    input  logic [MON_W-1:0] mon,
    output logic             hit
);
    logic [MON_W-1:0] prev_q;
    logic             seen_q;

    always_comb begin
        if (cmp_prev) hit = smp && seen_q && (mon != prev_q);
        else          hit = smp && (mon == target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            seen_q <= 1'b0;
        end else if (clr) begin
            seen_q <= 1'b0;
        end else if (smp) begin
            prev_q <= mon;
            seen_q <= 1'b1;
        end
    end

    AST_FIRST_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && cmp_prev && !seen_q) |-> !hit); // R8
    AST_HISTORY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !clr) |=> (prev_q == $past(mon))); // R7
endmodule

// File: rtl/csw_fsm.sv
module csw_fsm
    import csw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm_stop,
    input  logic             arm_sleep,
    input  logic             ext_wake,
    input  logic [1:0]       mode,
    input  logic             sup_cfg,
    input  logic [CNT_W-1:0] on_time,
    input  logic [CNT_W-1:0] win_start,
    input  logic [CNT_W-1:0] phase,
    input  logic [CNT_W-1:0] phase_nxt,
    input  logic             wrap,
    input  logic             sense_hit,
    output logic             clr,
    output logic             adv,
    output logic             smp,
    output logic             hs_en,
    output logic             sup_en,
    output logic             sample_stb,
    output logic             wake_req,
    output logic [1:0]       wake_src
);
    csw_state_e st_q, st_n;
    logic [1:0] src_q, src_n;
    logic       stop_q, stop_n;
    logic       go, sense_mode, timer_mode, armed;

    assign sense_mode = (mode == CM_SENSE);
    assign timer_mode = (mode == CM_TIMER);
    assign go         = (arm_stop || arm_sleep) && (sense_mode || timer_mode);
    assign armed      = (st_q == ST_BIAS) || (st_q == ST_REST);
    assign clr        = (st_q == ST_IDLE) && go;
    assign adv        = armed && tick && !ext_wake;
    assign smp        = adv && (st_q == ST_BIAS) && (phase == win_start);

    // next-state
    always_comb begin
        st_n   = st_q;
        src_n  = src_q;
        stop_n = stop_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go) begin
                    st_n   = (sense_mode && on_time != '0) ? ST_BIAS : ST_REST;
                    src_n  = SRC_NONE;
                    stop_n = arm_stop;
                end
            end
            ST_BIAS, ST_REST: begin
                if (ext_wake) begin
                    st_n  = ST_WAKE;
                    src_n = SRC_EXT;
                end else if (tick) begin
                    if (sense_hit) begin
                        st_n  = ST_WAKE;
                        src_n = SRC_SENSE;
                    end else if (timer_mode && wrap) begin
                        st_n  = ST_WAKE;
                        src_n = SRC_TIMER;
                    end else if (sense_mode && phase_nxt < on_time) begin
                        st_n = ST_BIAS;
                    end else begin
                        st_n = ST_REST;
                    end
                end
            end
            ST_WAKE: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            src_q  <= SRC_NONE;
            stop_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            src_q  <= src_n;
            stop_q <= stop_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_en      <= 1'b0;
            sup_en     <= 1'b0;
            sample_stb <= 1'b0;
            wake_req   <= 1'b0;
        end else begin
            hs_en      <= (st_n == ST_BIAS);
            sup_en     <= (st_n == ST_BIAS) && stop_n && sup_cfg;
            sample_stb <= smp;
            wake_req   <= (st_n == ST_WAKE);
        end
    end

    assign wake_src = src_q;

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req); // R11
    AST_QUIET_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> (!hs_en && !sup_en)); // R11
    AST_SUP_NEEDS_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        sup_en |-> hs_en); // R9
    AST_STB_IN_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(hs_en)); // R5
    AST_EXT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ext_wake) |=> (wake_req && wake_src == SRC_EXT)); // R10
    AST_IDLE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> !wake_req); // R2
endmodule

// File: rtl/cyc_sense_wake.sv
module cyc_sense_wake
    import csw_pkg::*;
#(
    parameter int MON_W = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm_stop,
    input  logic             arm_sleep,
    input  logic             ext_wake,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_cmp_prev,
    input  logic             cfg_sup_en,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_on_time,
    input  logic [CNT_W-1:0] cfg_win_start,
    input  logic [MON_W-1:0] cfg_target,
    input  logic [MON_W-1:0] mon_in,
    output logic             hs_en,
    output logic             sup_en,
    output logic             sample_stb,
    output logic             wake_req,
    output logic [1:0]       wake_src
);
    logic             clr, adv, smp, wrap, hit;
    logic [CNT_W-1:0] phase, phase_nxt;

    csw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .adv       (adv),
        .period    (cfg_period),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .wrap      (wrap)
    );

    csw_pattern_eval #(.MON_W(MON_W)) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .smp      (smp),
        .cmp_prev (cfg_cmp_prev),
        .target   (cfg_target),
        .mon      (mon_in),
        .hit      (hit)
    );

    csw_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .arm_stop   (arm_stop),
        .arm_sleep  (arm_sleep),
        .ext_wake   (ext_wake),
        .mode       (cfg_mode),
        .sup_cfg    (cfg_sup_en),
        .on_time    (cfg_on_time),
        .win_start  (cfg_win_start),
        .phase      (phase),
        .phase_nxt  (phase_nxt),
        .wrap       (wrap),
        .sense_hit  (hit),
        .clr        (clr),
        .adv        (adv),
        .smp        (smp),
        .hs_en      (hs_en),
        .sup_en     (sup_en),
        .sample_stb (sample_stb),
        .wake_req   (wake_req),
        .wake_src   (wake_src)
    );

    AST_SENSE_SRC_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && wake_src == SRC_SENSE) |-> sample_stb); // R6
    AST_TIMER_NO_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == CM_TIMER && !wake_req) |-> !hs_en); // R3
endmodule

// File: tb/sim_cyc_sense_wake.sv
`timescale 1ns/1ps
module sim_cyc_sense_wake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, arm_stop = 1'b0, arm_sleep = 1'b0, ext_wake = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_cmp_prev = 1'b0, cfg_sup_en = 1'b0;
    logic [7:0] cfg_period = 8'd4, cfg_on_time = 8'd2, cfg_win_start = 8'd0;
    logic [4:0] cfg_target = 5'd0, mon_in = 5'd0;
    logic       hs_en, sup_en, sample_stb, wake_req;
    logic [1:0] wake_src;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    logic got_stb, got_wake;
    logic [1:0] got_src;

    always #5 clk = ~clk;

    cyc_sense_wake u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm_stop(arm_stop),
        .arm_sleep(arm_sleep), .ext_wake(ext_wake), .cfg_mode(cfg_mode),
        .cfg_cmp_prev(cfg_cmp_prev), .cfg_sup_en(cfg_sup_en),
        .cfg_period(cfg_period), .cfg_on_time(cfg_on_time),
        .cfg_win_start(cfg_win_start), .cfg_target(cfg_target),
        .mon_in(mon_in), .hs_en(hs_en), .sup_en(sup_en),
        .sample_stb(sample_stb), .wake_req(wake_req), .wake_src(wake_src)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at a negedge
    task automatic tick_once();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        got_stb  = sample_stb;
        got_wake = wake_req;
        got_src  = wake_src;
        @(negedge clk);
    endtask

    task automatic arm(input bit stop);
        if (stop) arm_stop = 1'b1; else arm_sleep = 1'b1;
        @(negedge clk);
        arm_stop = 1'b0;
        arm_sleep = 1'b0;
    endtask

    task automatic quit();
        ext_wake = 1'b1;
        @(negedge clk);
        ext_wake = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int widx, nwake;
        logic [1:0] wsrc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({hs_en, sup_en, sample_stb, wake_req, wake_src} == 6'd0, "R1 reset outputs", int'(hs_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({hs_en, sup_en, sample_stb, wake_req, wake_src} == 6'd0, "R1 after release", int'(wake_req), 0);

        // R2 off modes ignore commands
        for (int m = 0; m < 4; m += 3) begin
            cfg_mode = 2'(m);
            cfg_period = 8'd2;
            arm(1'b1);
            nwake = 0;
            for (int k = 0; k < 6; k++) begin
                chk(hs_en == 1'b0, "R2 off mode no drive", int'(hs_en), 0);
                tick_once();
                if (got_wake) nwake++;
            end
            chk(nwake == 0, "R2 off mode no wake", nwake, 0);
        end

        // R3 timer wake sweep
        cfg_mode = 2'd1;
        for (int p = 0; p <= 6; p++) begin
            cfg_period = 8'(p);
            arm(p[0]);
            widx = 0; nwake = 0; wsrc = 2'd0;
            for (int k = 1; k <= 10; k++) begin
                tick_once();
                if (got_wake) begin
                    nwake++;
                    if (widx == 0) begin widx = k; wsrc = got_src; end
                end
            end
            chk(widx == ((p == 0) ? 1 : p), "R3 timer wake tick", widx, (p == 0) ? 1 : p);
            chk(wsrc == 2'd1, "R3 timer wake source", int'(wsrc), 1);
            chk(nwake == 1, "R11 single wake then idle", nwake, 1);
            chk(hs_en == 1'b0, "R11 idle after wake", int'(hs_en), 0);
        end

        // R4 bias window sweep (target unreachable)
        cfg_mode = 2'd2; cfg_cmp_prev = 1'b0; cfg_target = 5'h1F; mon_in = 5'h00;
        cfg_period = 8'd4; cfg_win_start = 8'd0;
        for (int o = 0; o <= 4; o++) begin
            cfg_on_time = 8'(o);
            arm(1'b0);
            for (int k = 0; k < 12; k++) begin
                chk(hs_en == ((k % 4) < o), "R4 bias on-time", int'(hs_en), int'((k % 4) < o));
                tick_once();
            end
            quit();
        end

        // R5 strobe position sweep
        cfg_on_time = 8'd2;
        for (int w = 0; w < 4; w++) begin
            cfg_win_start = 8'(w);
            arm(1'b0);
            for (int k = 0; k < 8; k++) begin
                tick_once();
                chk(got_stb == ((k % 4) == w && w < 2), "R5 strobe in window",
                    int'(got_stb), int'((k % 4) == w && w < 2));
            end
            quit();
        end

        // R6 target compare
        cfg_win_start = 8'd1; cfg_target = 5'h0A; mon_in = 5'h0A;
        arm(1'b0);
        widx = -1; wsrc = 2'd0;
        for (int k = 0; k < 8; k++) begin
            tick_once();
            if (got_wake && widx < 0) begin widx = k; wsrc = got_src; end
        end
        chk(widx == 1, "R6 target match wakes at window", widx, 1);
        chk(wsrc == 2'd2, "R6 sense wake source", int'(wsrc), 2);
        mon_in = 5'h0B;
        arm(1'b0);
        nwake = 0;
        for (int k = 0; k < 8; k++) begin tick_once(); if (got_wake) nwake++; end
        chk(nwake == 0, "R6 mismatch no wake", nwake, 0);
        quit();

        // R8 first snapshot in compare-to-previous mode
        cfg_cmp_prev = 1'b1; mon_in = 5'h15;
        arm(1'b1);
        nwake = 0;
        for (int k = 0; k < 3; k++) begin tick_once(); if (got_wake) nwake++; end
        chk(nwake == 0, "R8 first sample never wakes", nwake, 0);
        quit();

        // R7 change detected at the third window
        mon_in = 5'h03;
        arm(1'b0);
        widx = -1; wsrc = 2'd0;
        for (int k = 0; k < 16; k++) begin
            if (k == 9) mon_in = 5'h04;
            tick_once();
            if (got_wake && widx < 0) begin widx = k; wsrc = got_src; end
        end
        chk(widx == 9, "R7 change wakes at next window", widx, 9);
        chk(wsrc == 2'd2, "R7 sense wake source", int'(wsrc), 2);

        // R9 sensor supply only with stop
        cfg_cmp_prev = 1'b0; cfg_target = 5'h1F; mon_in = 5'h00; cfg_sup_en = 1'b1;
        arm(1'b1);
        chk(hs_en && sup_en, "R9 stop arms supply", int'(sup_en), 1);
        quit();
        arm(1'b0);
        chk(hs_en && !sup_en, "R9 sleep keeps supply off", int'(sup_en), 0);
        quit();
        cfg_sup_en = 1'b0;
        arm(1'b1);
        chk(hs_en && !sup_en, "R9 supply bit clear", int'(sup_en), 0);

        // R10 external wake while armed
        ext_wake = 1'b1;
        @(negedge clk);
        ext_wake = 1'b0;
        chk(wake_req == 1'b1 && wake_src == 2'd3, "R10 external wake", int'(wake_src), 3);
        @(negedge clk);
        chk(wake_req == 1'b0 && hs_en == 1'b0, "R11 pulse ends", int'(wake_req), 0);
        ext_wake = 1'b1;
        @(negedge clk);
        ext_wake = 1'b0;
        chk(wake_req == 1'b0, "R10 external ignored when idle", int'(wake_req), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule